// File: doc/BRIEF.md
# Shared-Domain Clock Ratio Governor

This block chooses the clock ratio of a clock domain that several cores share, such as the fabric around the last-level cache. Software sets a window with a lowest and a highest allowed ratio. Inside that window a hardware loop counts demand events, such as cache accesses, and moves the ratio up or down by one step. It moves only after demand has stayed high, or stayed low, for several update periods in a row. Setting the lowest and highest ratio to the same value pins the domain to that one ratio.

The block acts only on a slow periodic update tick. A request that arrives just after a tick waits almost a full period. One that arrives just before a tick is taken almost at once. Every switch is followed by a fixed blackout. During the blackout a busy flag is high and the domain is unusable. The new ratio appears when the blackout ends, and a one-cycle done pulse marks it. When the package power limit input is high at a tick, the governor steps the ratio down by one. This happens even below the window minimum, so a programmed window is only a recommendation while power is constrained. All timing values are module parameters counted in reference-clock cycles.

Top module: `uclk_ratio_gov`

## Requirements
- R1: After reset the ratio output is HW_MIN, the window reads back as HW_MIN..HW_MAX, and busy and switch_done are 0.
- R2: A window write takes effect on the next clock edge. It is accepted only when HW_MIN <= new minimum <= new maximum <= HW_MAX. Any other write is rejected and the stored window keeps its previous value.
- R3: The update tick fires once every TICK_CYC cycles. The first tick is at the TICK_CYC-th rising edge after reset is released. A switch can begin only at a tick.
- R4: At each tick the demand events counted over that window, including the tick cycle, are classified. The count saturates at 2^CNT_W-1. A count of HI_THR or more is high, a count of LO_THR or less is low, and anything between is neutral.
- R5: A target step of +1 occurs after PERSIST high windows in a row. A step of -1 occurs after PERSIST low windows in a row. A neutral window, or a window of the opposite kind, restarts both streaks, and every step also restarts the streak.
- R6: Without the power limit, the candidate ratio at a tick is the current ratio plus the step, clamped into the stored window. A pinned window therefore forces its value at the next tick, from any current ratio.
- R7: When power_limit is high at a tick, the candidate is the current ratio minus one, with a floor of HW_MIN. This candidate ignores the window minimum and any demand step.
- R8: A switch holds busy high for exactly BLACKOUT_CYC cycles. The ratio output takes its new value at the same edge where busy falls, and switch_done is high for exactly that one cycle.
- R9: When the candidate equals the current ratio, no switch starts, busy stays low and the ratio output does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the ratio window |
| cfg_min | input | RATIO_W | Requested lowest ratio |
| cfg_max | input | RATIO_W | Requested highest ratio |
| acc_evt | input | 1 | One demand event in this cycle |
| power_limit | input | 1 | Package power limit is active |
| lim_min | output | RATIO_W | Stored window minimum |
| lim_max | output | RATIO_W | Stored window maximum |
| ratio | output | RATIO_W | Ratio currently applied to the domain |
| busy | output | 1 | Switch blackout in progress |
| switch_done | output | 1 | One-cycle pulse when a new ratio has been applied |

## Verification
Several faults show up at the ports quickly:
- **Window register:** a fault shows on lim_min and lim_max at the first edge after the write.
- **Blackout counter:** a fault shows as a busy period of the wrong length, or as a ratio change with no done pulse in the same cycle.
- **Clamp or power override:** a fault shows one blackout after the next tick, as a ratio outside the window or not lowered.

Faults in the tick counter or in the demand streaks are slower to appear. They show several tick periods later, as a step that arrives a window early, a window late or not at all. The bench therefore compares every port every cycle against an independent cycle model, so the first wrong cycle is reported.

// File: rtl/ucg_pkg.sv
package ucg_pkg;
    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DN   = 2'd2
    } step_e;
endpackage

// File: rtl/ucg_limits.sv
module ucg_limits #(
    parameter int RATIO_W = 6,
    parameter int HW_MIN  = 8,
    parameter int HW_MAX  = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [RATIO_W-1:0] wr_min,
    input  logic [RATIO_W-1:0] wr_max,
    output logic [RATIO_W-1:0] lo,
    output logic [RATIO_W-1:0] hi
);
    localparam logic [RATIO_W-1:0] FLOOR = RATIO_W'(HW_MIN);
    localparam logic [RATIO_W-1:0] CEIL  = RATIO_W'(HW_MAX);

    typedef struct packed {
        logic [RATIO_W-1:0] lo;
        logic [RATIO_W-1:0] hi;
    } lim_t;

    lim_t s_d, s_q;
    logic legal;

    always_comb begin
        s_d   = s_q;
        legal = (wr_min <= wr_max) && (wr_min >= FLOOR) && (wr_max <= CEIL);
        if (wr && legal) begin
            s_d.lo = wr_min;
            s_d.hi = wr_max;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.lo <= FLOOR;
            s_q.hi <= CEIL;
        end else begin
            s_q <= s_d;
        end
    end

    assign lo = s_q.lo;
    assign hi = s_q.hi;
endmodule

// File: rtl/ucg_demand.sv
module ucg_demand
    import ucg_pkg::*;
#(
    parameter int TICK_CYC = 32,
    parameter int CNT_W    = 6,
    parameter int HI_THR   = 20,
    parameter int LO_THR   = 6,
    parameter int PERSIST  = 3
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  acc_evt,
    output logic  tick,
    output step_e step
);
    localparam int TW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
    localparam int SW = $clog2(PERSIST + 1);
    localparam logic [TW-1:0]    TICK_LAST = TW'(TICK_CYC - 1);
    localparam logic [CNT_W-1:0] CNT_MAX   = '1;
    localparam logic [SW-1:0]    RUN_LAST  = SW'(PERSIST - 1);

    typedef struct packed {
        logic [TW-1:0]    tcnt;
        logic [CNT_W-1:0] ecnt;
        logic [SW-1:0]    ups;
        logic [SW-1:0]    dns;
    } dem_t;

    dem_t s_d, s_q;
    logic [CNT_W-1:0] sample;

    always_comb begin
        s_d    = s_q;
        step   = STEP_NONE;
        tick   = (s_q.tcnt == TICK_LAST);
        sample = (acc_evt && s_q.ecnt != CNT_MAX) ? s_q.ecnt + 1'b1 : s_q.ecnt;
        s_d.tcnt = tick ? '0 : s_q.tcnt + 1'b1;
        if (tick) begin
            s_d.ecnt = '0;
            if (sample >= CNT_W'(HI_THR)) begin
                s_d.dns = '0;
                if (s_q.ups == RUN_LAST) begin
                    step    = STEP_UP;
                    s_d.ups = '0;
                end else begin
                    s_d.ups = s_q.ups + 1'b1;
                end
            end else if (sample <= CNT_W'(LO_THR)) begin
                s_d.ups = '0;
                if (s_q.dns == RUN_LAST) begin
                    step    = STEP_DN;
                    s_d.dns = '0;
                end else begin
                    s_d.dns = s_q.dns + 1'b1;
                end
            end else begin
                s_d.ups = '0;
                s_d.dns = '0;
            end
        end else begin
            s_d.ecnt = sample;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/ucg_seq.sv
module ucg_seq
    import ucg_pkg::*;
#(
    parameter int RATIO_W     = 6,
    parameter int HW_MIN      = 8,
    parameter int BLACKOUT_CYC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  step_e              step,
    input  logic               power_limit,
    input  logic [RATIO_W-1:0] lo,
    input  logic [RATIO_W-1:0] hi,
    output logic [RATIO_W-1:0] ratio,
    output logic               busy,
    output logic               done
);
    localparam int BW = (BLACKOUT_CYC > 1) ? $clog2(BLACKOUT_CYC) : 1;
    localparam logic [RATIO_W-1:0] FLOOR = RATIO_W'(HW_MIN);
    localparam logic [BW-1:0]      BLK_LAST = BW'(BLACKOUT_CYC - 1);

    typedef struct packed {
        logic [RATIO_W-1:0] ratio;
        logic [RATIO_W-1:0] pend;
        logic               busy;
        logic [BW-1:0]      bcnt;
        logic               done;
    } seq_t;

    seq_t s_d, s_q;
    logic [RATIO_W:0]   base;
    logic [RATIO_W-1:0] cand;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        case (step)
            STEP_UP: base = {1'b0, s_q.ratio} + 1'b1;
            STEP_DN: base = {1'b0, s_q.ratio} - 1'b1;
            default: base = {1'b0, s_q.ratio};
        endcase
        if (power_limit) begin
            cand = (s_q.ratio > FLOOR) ? s_q.ratio - 1'b1 : s_q.ratio;
        end else if (base < {1'b0, lo}) begin
            cand = lo;
        end else if (base > {1'b0, hi}) begin
            cand = hi;
        end else begin
            cand = base[RATIO_W-1:0];
        end
        if (s_q.busy) begin
            if (s_q.bcnt == '0) begin
                s_d.busy  = 1'b0;
                s_d.ratio = s_q.pend;
                s_d.done  = 1'b1;
            end else begin
                s_d.bcnt = s_q.bcnt - 1'b1;
            end
        end else if (tick && cand != s_q.ratio) begin
            s_d.busy = 1'b1;
            s_d.bcnt = BLK_LAST;
            s_d.pend = cand;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.ratio <= FLOOR;
            s_q.pend  <= FLOOR;
        end else begin
            s_q <= s_d;
        end
    end

    assign ratio = s_q.ratio;
    assign busy  = s_q.busy;
    assign done  = s_q.done;
endmodule

// File: rtl/uclk_ratio_gov.sv
module uclk_ratio_gov
    import ucg_pkg::*;
#(
    parameter int RATIO_W      = 6,
    parameter int HW_MIN       = 8,
    parameter int HW_MAX       = 20,
    parameter int TICK_CYC     = 32,
    parameter int BLACKOUT_CYC = 8,
    parameter int CNT_W        = 6,
    parameter int HI_THR       = 20,
    parameter int LO_THR       = 6,
    parameter int PERSIST      = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [RATIO_W-1:0] cfg_min,
    input  logic [RATIO_W-1:0] cfg_max,
    input  logic               acc_evt,
    input  logic               power_limit,
    output logic [RATIO_W-1:0] lim_min,
    output logic [RATIO_W-1:0] lim_max,
    output logic [RATIO_W-1:0] ratio,
    output logic               busy,
    output logic               switch_done
);
    logic  tick;
    step_e step;

    ucg_limits #(.RATIO_W(RATIO_W), .HW_MIN(HW_MIN), .HW_MAX(HW_MAX)) u_lim (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wr_min(cfg_min), .wr_max(cfg_max),
        .lo(lim_min), .hi(lim_max)
    );

    ucg_demand #(.TICK_CYC(TICK_CYC), .CNT_W(CNT_W), .HI_THR(HI_THR),
                 .LO_THR(LO_THR), .PERSIST(PERSIST)) u_dem (
        .clk(clk), .rst_n(rst_n), .acc_evt(acc_evt), .tick(tick), .step(step)
    );

    ucg_seq #(.RATIO_W(RATIO_W), .HW_MIN(HW_MIN), .BLACKOUT_CYC(BLACKOUT_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .step(step), .power_limit(power_limit),
        .lo(lim_min), .hi(lim_max), .ratio(ratio), .busy(busy), .done(switch_done)
    );
endmodule

// File: rtl/ucg_checker.sv
module ucg_checker #(
    parameter int RATIO_W      = 6,
    parameter int HW_MIN       = 8,
    parameter int HW_MAX       = 20,
    parameter int BLACKOUT_CYC = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [RATIO_W-1:0] lim_min,
    input logic [RATIO_W-1:0] lim_max,
    input logic [RATIO_W-1:0] ratio,
    input logic               busy,
    input logic               switch_done
);
    logic [31:0] busy_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_run_q <= '0;
        else if (busy) busy_run_q <= busy_run_q + 1;
        else           busy_run_q <= '0;
    end

    // R8: blackout lasts exactly BLACKOUT_CYC cycles
    p_blackout_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> busy_run_q == BLACKOUT_CYC);

    // R8: done appears only as busy falls
    p_done_with_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        switch_done |-> ($past(busy) && !busy));

    // R8: done is a single-cycle pulse
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        switch_done |=> !switch_done);

    // R3: ratio output only moves at the end of a blackout
    p_ratio_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(busy) |-> $stable(ratio));

    // R2: stored window is always ordered and inside the hardware range
    p_window_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_min <= lim_max) && (lim_min >= RATIO_W'(HW_MIN)) && (lim_max <= RATIO_W'(HW_MAX)));

    // R7: even under power override the ratio never leaves the hardware range
    p_ratio_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio >= RATIO_W'(HW_MIN)) && (ratio <= RATIO_W'(HW_MAX)));
endmodule

bind uclk_ratio_gov ucg_checker #(
    .RATIO_W(RATIO_W), .HW_MIN(HW_MIN), .HW_MAX(HW_MAX), .BLACKOUT_CYC(BLACKOUT_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .lim_min(lim_min), .lim_max(lim_max),
    .ratio(ratio), .busy(busy), .switch_done(switch_done)
);

// File: tb/tb_uclk_ratio_gov.sv
`timescale 1ns/1ps
module tb_uclk_ratio_gov;
    localparam int RW = 6, HWMIN = 8, HWMAX = 20, TICK = 32, BLK = 8;
    localparam int CW = 6, HI = 20, LO = 6, PER = 3;
    localparam int CNT_MAX = (1 << CW) - 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_wr = 1'b0, acc_evt = 1'b0, power_limit = 1'b0;
    logic [RW-1:0] cfg_min = '0, cfg_max = '0;
    logic [RW-1:0] lim_min, lim_max, ratio;
    logic busy, switch_done;

    int checks = 0, failures = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    uclk_ratio_gov #(.RATIO_W(RW), .HW_MIN(HWMIN), .HW_MAX(HWMAX), .TICK_CYC(TICK),
        .BLACKOUT_CYC(BLK), .CNT_W(CW), .HI_THR(HI), .LO_THR(LO), .PERSIST(PER)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_min(cfg_min), .cfg_max(cfg_max),
        .acc_evt(acc_evt), .power_limit(power_limit), .lim_min(lim_min), .lim_max(lim_max),
        .ratio(ratio), .busy(busy), .switch_done(switch_done));

    function automatic int clampi(int v, int lo, int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    // R6 R7: candidate ratio at a tick
    function automatic int next_ratio(int r, int stp, bit pwr, int lo, int hi);
        if (pwr) return (r > HWMIN) ? r - 1 : r;
        return clampi(r + stp, lo, hi);
    endfunction

    function automatic bit legal_win(int lo, int hi);
        return (lo <= hi) && (lo >= HWMIN) && (hi <= HWMAX);
    endfunction

    int m_t, m_e, m_up, m_dn, m_r, m_pend, m_busy, m_bc, m_done, m_lo, m_hi;

    task automatic model_reset();
        m_t = 0; m_e = 0; m_up = 0; m_dn = 0; m_r = HWMIN; m_pend = HWMIN;
        m_busy = 0; m_bc = 0; m_done = 0; m_lo = HWMIN; m_hi = HWMAX;
    endtask

    initial model_reset();

    always @(posedge clk or negedge rst_n) begin : model
        int tk, samp, stp, cand, o_lo, o_hi;
        if (!rst_n) begin
            model_reset();
        end else begin
            o_lo = m_lo; o_hi = m_hi;
            tk   = (m_t == TICK - 1);
            samp = (acc_evt && m_e < CNT_MAX) ? m_e + 1 : m_e;
            stp  = 0;
            if (tk) begin
                if (samp >= HI) begin
                    m_dn = 0;
                    if (m_up == PER - 1) begin stp = 1; m_up = 0; end else m_up++;
                end else if (samp <= LO) begin
                    m_up = 0;
                    if (m_dn == PER - 1) begin stp = -1; m_dn = 0; end else m_dn++;
                end else begin
                    m_up = 0; m_dn = 0;
                end
                m_e = 0;
            end else begin
                m_e = samp;
            end
            m_t  = tk ? 0 : m_t + 1;
            m_done = 0;
            if (m_busy != 0) begin
                if (m_bc == 0) begin m_busy = 0; m_r = m_pend; m_done = 1; end
                else m_bc--;
            end else if (tk) begin
                cand = next_ratio(m_r, stp, power_limit, o_lo, o_hi);
                if (cand != m_r) begin m_busy = 1; m_bc = BLK - 1; m_pend = cand; end
            end
            if (cfg_wr && legal_win(cfg_min, cfg_max)) begin
                m_lo = cfg_min; m_hi = cfg_max;
            end
        end
    end

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R5", "ratio", ratio, m_r);
            check("R8", "busy", busy, m_busy);
            check("R8", "switch_done", switch_done, m_done);
            check("R2", "lim_min", lim_min, m_lo);
            check("R2", "lim_max", lim_max, m_hi);
        end
    end

    int dens = 0;
    bit alt = 0;
    bit busy_seen = 0;

    always @(negedge clk) begin
        if (busy) busy_seen <= 1'b1;
    end

    task automatic run_cycles(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (alt) acc_evt = ~acc_evt;
            else     acc_evt = (($urandom % 100) < dens);
        end
    endtask

    task automatic write_cfg(int lo, int hi);
        @(negedge clk);
        cfg_min = RW'(lo); cfg_max = RW'(hi); cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic finish_run();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        int r0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "ratio", ratio, HWMIN);
        check("R1", "lim_min", lim_min, HWMIN);
        check("R1", "lim_max", lim_max, HWMAX);
        check("R1", "busy", busy, 0);
        check("R1", "switch_done", switch_done, 0);
        rst_n = 1'b1;

        // R3 R5: full demand ramps the ratio up one step every PER ticks
        dens = 100;
        run_cycles(TICK * 10);
        check("R5", "ratio after ramp", ratio, HWMIN + 3);

        // R4 R9: exactly half the cycles carry events -> neutral, no switch
        alt = 1; dens = 0;
        run_cycles(TICK * 2);
        while (busy) run_cycles(1);
        r0 = ratio; busy_seen = 0;
        run_cycles(TICK * 6);
        check("R4", "neutral window keeps ratio", ratio, r0);
        check("R9", "no blackout when unchanged", busy_seen, 0);
        alt = 0; acc_evt = 1'b0;

        // R2: rejected writes keep the window
        write_cfg(15, 10);
        check("R2", "reject min>max lo", lim_min, HWMIN);
        check("R2", "reject min>max hi", lim_max, HWMAX);
        write_cfg(4, 10);
        check("R2", "reject below floor", lim_min, HWMIN);
        write_cfg(10, 14);
        check("R2", "accept lo", lim_min, 10);
        check("R2", "accept hi", lim_max, 14);

        // R6: pin forces the value at the next tick
        write_cfg(12, 12);
        dens = 40;
        run_cycles(TICK * 2);
        check("R6", "pinned ratio", ratio, 12);

        // R7: power limit pushes below the pinned value down to the floor
        power_limit = 1'b1;
        run_cycles(TICK * 6);
        check("R7", "power override floor", ratio, HWMIN);
        power_limit = 1'b0;
        run_cycles(TICK * 2);
        check("R6", "return to pin after power", ratio, 12);

        write_cfg(HWMIN, HWMAX);
        // random mix
        for (int k = 0; k < 80; k++) begin
            case ($urandom % 5)
                0: dens = 0;
                1: dens = 15;
                2: dens = 40;
                3: dens = 70;
                default: dens = 100;
            endcase
            power_limit = (($urandom % 100) < 20);
            if (($urandom % 100) < 15) write_cfg(6 + ($urandom % 17), 6 + ($urandom % 17));
            run_cycles(TICK / 2 + ($urandom % TICK));
        end
        power_limit = 1'b0;
        run_cycles(TICK);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            finish_run();
        end
    end
endmodule